// File: doc/BRIEF.md
# Beacon Superframe Slot Timer

This block derives the full timing of a beacon-paced superframe from a symbol-rate tick. The superframe starts with a beacon. The interval between beacons is 960 symbols scaled by 2^`bo`. The leading active part is 960 symbols scaled by 2^`so`, and the rest of the interval up to the next beacon is quiet. The block does not run until `sync_start` is asserted, which a node raises when it sends or receives a beacon. The same input realigns a timer that is already running.

Inside the active part the block produces several timing outputs. It gives strobes on each 20-symbol backoff boundary. It divides the active part into sixteen equal slots and gives a strobe and an index for each slot. It also marks a contention window and a contention-free window. In standard mode the contention-free tail is `cfp_slots` slots long, from 0 to 7. In the time-division mode there is no contention window: the active part is shared into eight equal node slots. The `own_slot` output enables a node only inside the slot given by `node_slot`, and only while it has data waiting. A configuration whose active part would be longer than its interval is refused: the block raises an error flag and stops.

Top module: `superframe_timer`

## Requirements
- R1: After reset, and until the first accepted `sync_start`, every timing output (`beacon_pulse`, `active`, `inactive`, `cap_win`, `cfp_win`, `backoff_strobe`, `slot_strobe`, `slot_idx`, `own_slot`) is 0.
- R2: A `sync_start` sampled while `cfg_err` is low places the timer at symbol 0 of a new superframe, whether the timer is idle or running, and takes priority over `sym_tick`. In the next cycle `beacon_pulse` is 1 and `active` is 1.
- R3: When `sym_tick` is 1 every cycle, the timer advances one symbol position per sampled `sym_tick`. It wraps to position 0 after 960·2^`bo` positions, and `beacon_pulse` is high for exactly one cycle at each wrap.
- R4: `active` is 1 for positions below 960·2^`so`. `inactive` is 1 for the remaining positions of the interval. The two are never 1 together.
- R5: `backoff_strobe` pulses for one cycle after each tick that enters a position that is a multiple of 20, counted from the start of the superframe. It pulses only inside the active part.
- R6: The active part is split into 16 slots of 60·2^`so` symbols. `slot_idx` gives the current slot number 0..15 while `active` is 1, and is 0 otherwise. `slot_strobe` pulses on entry to each slot.
- R7: In standard mode (`tdm_mode`=0), `cap_win` covers slots 0 to 15−`cfp_slots` and `cfp_win` covers the remaining slots of the active part. The contention window therefore always lasts at least 540·2^`so` symbols, which is more than 440.
- R8: In time-division mode (`tdm_mode`=1), `cap_win` is never 1 and `cfp_win` equals `active`. `own_slot` is 1 exactly when `slot_idx`/2 equals `node_slot` and `data_pending` is 1.
- R9: While `data_pending` is 0, `own_slot` stays 0.
- R10: If `so` > `bo` or `bo` > 14, `cfg_err` is 1 in the same cycle and every timing output is 0. The timer stops and ignores `sync_start`. After the configuration is corrected, it stays idle until a new `sync_start`.
- R11: A cycle without `sym_tick` does not move the timer, and no pulse repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_tick | input | 1 | One-cycle pulse per symbol period |
| sync_start | input | 1 | Beacon alignment: restart at symbol 0 |
| bo | input | 4 | Interval order (0..14) |
| so | input | 4 | Active-part order (0..bo) |
| tdm_mode | input | 1 | 1 selects the time-division mode |
| cfp_slots | input | 3 | Contention-free slots in standard mode |
| node_slot | input | 3 | Node slot number in time-division mode |
| data_pending | input | 1 | The node has a frame to send |
| beacon_pulse | output | 1 | Superframe start pulse |
| active | output | 1 | Active-part level |
| inactive | output | 1 | Quiet-part level |
| cap_win | output | 1 | Contention window |
| cfp_win | output | 1 | Contention-free window |
| backoff_strobe | output | 1 | 20-symbol boundary pulse |
| slot_strobe | output | 1 | Slot entry pulse |
| slot_idx | output | 4 | Current slot number |
| own_slot | output | 1 | Node's own transmit slot enable |
| cfg_err | output | 1 | Orders out of range |

## Verification
A wrong position count shows first as a `slot_strobe` or `backoff_strobe` pulse on the wrong cycle. In the worst case it shows as a misplaced `beacon_pulse` at the end of the interval. The bench rebuilds the symbol position from its own tick count and compares every output in every cycle, so a drift is caught in the first cycle where it happens. A wrong window boundary shows within one slot, through `cap_win`, `cfp_win` or `own_slot` changing on the wrong side of the `slot_idx` step.

// File: rtl/sftimer_pkg.sv
package sftimer_pkg;
    // Default geometry of the superframe
    localparam int BASE_SYMS    = 960;
    localparam int SF_SLOTS     = 16;
    localparam int BACKOFF_SYMS = 20;
    localparam int TDM_SLOTS    = 8;
    localparam int GTS_MAX      = 7;
    localparam int MAX_ORDER    = 14;
    localparam int ORD_W        = 4;
endpackage

// File: rtl/sf_position.sv
// Symbol position tracker.
// Keeps the symbol count within the interval, the symbol count within the
// current slot, the slot number and the backoff phase.
// Assumes advance is only high while the configuration is valid.
module sf_position #(
    parameter int BASE_SYMS    = 960,
    parameter int SF_SLOTS     = 16,
    parameter int BACKOFF_SYMS = 20,
    parameter int MAX_ORDER    = 14,
    parameter int ORD_W        = 4,
    localparam int CNT_W       = $clog2(BASE_SYMS) + MAX_ORDER,
    localparam int SLOT_W      = $clog2(SF_SLOTS),
    localparam int BK_W        = $clog2(BACKOFF_SYMS),
    localparam int SLOT_SYMS   = BASE_SYMS / SF_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              restart,
    input  logic [ORD_W-1:0]  bo,
    input  logic [ORD_W-1:0]  so,
    output logic [CNT_W-1:0]  sym_cnt,
    output logic [CNT_W-1:0]  slot_sym,
    output logic [SLOT_W-1:0] slot_no,
    output logic [BK_W-1:0]   bk_cnt
);
    logic [CNT_W-1:0] bi_last;
    logic [CNT_W-1:0] slot_last;

    // Last position of the interval and of one slot
    always_comb begin
        bi_last   = (CNT_W'(BASE_SYMS) << bo) - CNT_W'(1);
        slot_last = (CNT_W'(SLOT_SYMS) << so) - CNT_W'(1);
    end

    // Advance all position counters on each accepted symbol tick
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sym_cnt  <= '0;
            slot_sym <= '0;
            slot_no  <= '0;
            bk_cnt   <= '0;
        end else if (advance) begin
            if (sym_cnt >= bi_last) begin
                sym_cnt  <= '0;
                slot_sym <= '0;
                slot_no  <= '0;
                bk_cnt   <= '0;
            end else begin
                sym_cnt <= sym_cnt + CNT_W'(1);
                bk_cnt  <= (bk_cnt == BK_W'(BACKOFF_SYMS - 1)) ? '0 : bk_cnt + BK_W'(1);
                if (slot_sym >= slot_last) begin
                    slot_sym <= '0;
                    slot_no  <= slot_no + SLOT_W'(1);
                end else begin
                    slot_sym <= slot_sym + CNT_W'(1);
                end
            end
        end
    end

    assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !restart) |=> $stable(sym_cnt) && $stable(slot_no) && $stable(bk_cnt));

    assert_backoff_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bk_cnt < BK_W'(BACKOFF_SYMS));
endmodule

// File: rtl/sf_window_decode.sv
// Window decoder.
// Turns the position counters into levels, pulses and the node-slot enable.
// Assumes fresh is high only in the cycle after the position changed.
module sf_window_decode #(
    parameter int BASE_SYMS    = 960,
    parameter int SF_SLOTS     = 16,
    parameter int TDM_SLOTS    = 8,
    parameter int GTS_MAX      = 7,
    parameter int MAX_ORDER    = 14,
    parameter int ORD_W        = 4,
    parameter int BACKOFF_SYMS = 20,
    localparam int CNT_W       = $clog2(BASE_SYMS) + MAX_ORDER,
    localparam int SLOT_W      = $clog2(SF_SLOTS),
    localparam int BK_W        = $clog2(BACKOFF_SYMS),
    localparam int NODE_W      = $clog2(TDM_SLOTS),
    localparam int GRP_SH      = SLOT_W - NODE_W,
    localparam int CFP_W       = $clog2(GTS_MAX + 1)
) (
    input  logic              live,
    input  logic              fresh,
    input  logic [CNT_W-1:0]  sym_cnt,
    input  logic [CNT_W-1:0]  slot_sym,
    input  logic [SLOT_W-1:0] slot_no,
    input  logic [BK_W-1:0]   bk_cnt,
    input  logic [ORD_W-1:0]  so,
    input  logic              tdm_mode,
    input  logic [CFP_W-1:0]  cfp_slots,
    input  logic [NODE_W-1:0] node_slot,
    input  logic              data_pending,
    output logic              beacon_pulse,
    output logic              active,
    output logic              inactive,
    output logic              cap_win,
    output logic              cfp_win,
    output logic              backoff_strobe,
    output logic              slot_strobe,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              own_slot
);
    logic              in_active;
    logic [SLOT_W:0]   cap_end;
    logic [NODE_W-1:0] node_of_slot;

    // Active part test and contention window end
    always_comb begin
        in_active    = sym_cnt < (CNT_W'(BASE_SYMS) << so);
        cap_end      = tdm_mode ? '0 : ((SLOT_W+1)'(SF_SLOTS) - (SLOT_W+1)'(cfp_slots));
        node_of_slot = slot_no[SLOT_W-1:GRP_SH];
    end

    // Output levels and pulses
    always_comb begin
        active         = live && in_active;
        inactive       = live && !in_active;
        cap_win        = active && ({1'b0, slot_no} < cap_end);
        cfp_win        = active && !cap_win;
        beacon_pulse   = live && fresh && (sym_cnt == '0);
        backoff_strobe = active && fresh && (bk_cnt == '0);
        slot_strobe    = active && fresh && (slot_sym == '0);
        slot_idx       = active ? slot_no : '0;
        own_slot       = active && tdm_mode && data_pending && (node_of_slot == node_slot);
    end
endmodule

// File: rtl/superframe_timer.sv
// Superframe timer top.
// Holds the run state, checks the orders and joins the position tracker
// to the window decoder. Assumes sym_tick is a one-cycle pulse per symbol.
module superframe_timer
    import sftimer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_tick,
    input  logic       sync_start,
    input  logic [3:0] bo,
    input  logic [3:0] so,
    input  logic       tdm_mode,
    input  logic [2:0] cfp_slots,
    input  logic [2:0] node_slot,
    input  logic       data_pending,
    output logic       beacon_pulse,
    output logic       active,
    output logic       inactive,
    output logic       cap_win,
    output logic       cfp_win,
    output logic       backoff_strobe,
    output logic       slot_strobe,
    output logic [3:0] slot_idx,
    output logic       own_slot,
    output logic       cfg_err
);
    localparam int CNT_W  = $clog2(BASE_SYMS) + MAX_ORDER;
    localparam int SLOT_W = $clog2(SF_SLOTS);
    localparam int BK_W   = $clog2(BACKOFF_SYMS);

    logic             running;
    logic             fresh;
    logic             advance;
    logic             restart;
    logic             live;
    logic [CNT_W-1:0] sym_cnt;
    logic [CNT_W-1:0] slot_sym;
    logic [SLOT_W-1:0] slot_no;
    logic [BK_W-1:0]  bk_cnt;

    // Order check and control strobes
    always_comb begin
        cfg_err = (so > bo) || (bo > ORD_W'(MAX_ORDER));
        restart = sync_start && !cfg_err;
        advance = running && sym_tick && !cfg_err;
        live    = running && !cfg_err;
    end

    // Run state and the one-cycle marker for a new position
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_err) begin
            running <= 1'b0;
            fresh   <= 1'b0;
        end else if (sync_start) begin
            running <= 1'b1;
            fresh   <= 1'b1;
        end else begin
            fresh   <= running && sym_tick;
        end
    end

    sf_position #(
        .BASE_SYMS(BASE_SYMS), .SF_SLOTS(SF_SLOTS), .BACKOFF_SYMS(BACKOFF_SYMS),
        .MAX_ORDER(MAX_ORDER), .ORD_W(ORD_W)
    ) i_pos (
        .clk(clk), .rst_n(rst_n), .advance(advance), .restart(restart),
        .bo(bo), .so(so), .sym_cnt(sym_cnt), .slot_sym(slot_sym),
        .slot_no(slot_no), .bk_cnt(bk_cnt)
    );

    sf_window_decode #(
        .BASE_SYMS(BASE_SYMS), .SF_SLOTS(SF_SLOTS), .TDM_SLOTS(TDM_SLOTS),
        .GTS_MAX(GTS_MAX), .MAX_ORDER(MAX_ORDER), .ORD_W(ORD_W),
        .BACKOFF_SYMS(BACKOFF_SYMS)
    ) i_dec (
        .live(live), .fresh(fresh), .sym_cnt(sym_cnt), .slot_sym(slot_sym),
        .slot_no(slot_no), .bk_cnt(bk_cnt), .so(so), .tdm_mode(tdm_mode),
        .cfp_slots(cfp_slots), .node_slot(node_slot), .data_pending(data_pending),
        .beacon_pulse(beacon_pulse), .active(active), .inactive(inactive),
        .cap_win(cap_win), .cfp_win(cfp_win), .backoff_strobe(backoff_strobe),
        .slot_strobe(slot_strobe), .slot_idx(slot_idx), .own_slot(own_slot)
    );

    assert_start_beacon_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_start && !cfg_err) |=> (beacon_pulse && active) || cfg_err);

    assert_levels_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({active, inactive}));

    assert_windows_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_win && cfp_win));

    assert_beacon_on_boundaries_R5: assert property (@(posedge clk) disable iff (!rst_n)
        beacon_pulse |-> backoff_strobe && slot_strobe && (slot_idx == '0));

    assert_tdm_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tdm_mode |-> !cap_win);

    assert_own_inside_cfp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        own_slot |-> cfp_win && tdm_mode);

    assert_no_data_no_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !data_pending |-> !own_slot);

    assert_error_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !active && !inactive && !beacon_pulse && !slot_strobe);
endmodule

// File: tb/test_superframe_timer.sv
module test_superframe_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_tick = 1'b0;
    logic       sync_start = 1'b0;
    logic [3:0] bo = 4'd0;
    logic [3:0] so = 4'd0;
    logic       tdm_mode = 1'b0;
    logic [2:0] cfp_slots = 3'd0;
    logic [2:0] node_slot = 3'd0;
    logic       data_pending = 1'b1;
    logic       beacon_pulse, active, inactive, cap_win, cfp_win;
    logic       backoff_strobe, slot_strobe, own_slot, cfg_err;
    logic [3:0] slot_idx;

    int checks = 0;
    int errors = 0;
    int pos = 0;
    bit fresh_m = 0;
    bit live_m = 0;

    always #5 clk = ~clk;

    superframe_timer i_superframe_timer (
        .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .sync_start(sync_start),
        .bo(bo), .so(so), .tdm_mode(tdm_mode), .cfp_slots(cfp_slots),
        .node_slot(node_slot), .data_pending(data_pending),
        .beacon_pulse(beacon_pulse), .active(active), .inactive(inactive),
        .cap_win(cap_win), .cfp_win(cfp_win), .backoff_strobe(backoff_strobe),
        .slot_strobe(slot_strobe), .slot_idx(slot_idx), .own_slot(own_slot),
        .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d pos=%0d", req, what, act, exp, pos);
        end
    endtask

    function automatic bit err_now();
        return (so > bo) || (bo > 4'd14);
    endfunction

    // Compare every output with the model position
    task automatic check_outputs();
        int sd, sl, idx, cap_end;
        bit act, capx;
        sd  = 960 << so;
        sl  = 60 << so;
        act = live_m && (pos < sd);
        idx = act ? pos / sl : 0;
        cap_end = tdm_mode ? 0 : 16 - int'(cfp_slots);
        capx = act && (idx < cap_end);
        chk("R4", "active", int'(active), int'(act));
        chk("R4", "inactive", int'(inactive), int'(live_m && !(pos < sd)));
        chk("R3", "beacon_pulse", int'(beacon_pulse), int'(live_m && fresh_m && pos == 0));
        chk("R5", "backoff_strobe", int'(backoff_strobe), int'(act && fresh_m && (pos % 20) == 0));
        chk("R6", "slot_strobe", int'(slot_strobe), int'(act && fresh_m && (pos % sl) == 0));
        chk("R6", "slot_idx", int'(slot_idx), idx);
        if (tdm_mode) begin
            chk("R8", "cap_win", int'(cap_win), 0);
            chk("R8", "cfp_win", int'(cfp_win), int'(act));
        end else begin
            chk("R7", "cap_win", int'(cap_win), int'(capx));
            chk("R7", "cfp_win", int'(cfp_win), int'(act && !capx));
        end
        if (data_pending)
            chk("R8", "own_slot", int'(own_slot), int'(act && tdm_mode && (idx / 2) == int'(node_slot)));
        else
            chk("R9", "own_slot", int'(own_slot), 0);
        chk("R10", "cfg_err", int'(cfg_err), int'(err_now()));
    endtask

    // One clock with a chosen tick value; model follows R3 and R11
    task automatic step(input bit tick);
        sym_tick = tick;
        @(posedge clk);
        if (err_now()) begin
            live_m = 0; fresh_m = 0;
        end else if (live_m && tick) begin
            pos = (pos + 1 >= (960 << bo)) ? 0 : pos + 1;
            fresh_m = 1;
        end else begin
            fresh_m = 0;
        end
        @(negedge clk);
        sym_tick = 0;
        check_outputs();
    endtask

    // Beacon alignment per R2
    task automatic do_start(input bit tick);
        sync_start = 1;
        sym_tick = tick;
        @(posedge clk);
        if (err_now()) begin
            live_m = 0; fresh_m = 0;
        end else begin
            live_m = 1; pos = 0; fresh_m = 1;
        end
        @(negedge clk);
        sync_start = 0;
        sym_tick = 0;
        check_outputs();
    endtask

    // One full interval plus a margin with a tick every cycle
    task automatic run_cfg(input int b, input int s, input bit t, input int c,
                           input int n, input bit d);
        int bi, cap_cnt, bcn;
        bo = 4'(b); so = 4'(s); tdm_mode = t; cfp_slots = 3'(c);
        node_slot = 3'(n); data_pending = d;
        bi = 960 << b;
        do_start(1'b1);
        chk("R2", "start beacon", int'(beacon_pulse && active), 1);
        cap_cnt = int'(cap_win);
        bcn = int'(beacon_pulse);
        for (int k = 1; k < bi + 40; k++) begin
            step(1'b1);
            if (k < bi) cap_cnt += int'(cap_win);
            bcn += int'(beacon_pulse);
        end
        chk("R3", "beacons per interval+margin", bcn, 2);
        if (t) chk("R8", "contention length", cap_cnt, 0);
        else begin
            chk("R7", "contention length", cap_cnt, (16 - c) * (60 << s));
            chk("R7", "contention at least 440", int'(cap_cnt >= 440), 1);
        end
    endtask

    initial begin
        #(10 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: idle after reset, ticks alone do not start it
        check_outputs();
        chk("R1", "idle active", int'(active), 0);
        for (int k = 0; k < 30; k++) step(1'b1);
        chk("R1", "idle slot_idx", int'(slot_idx), 0);

        // Sweep of orders and modes
        for (int b = 0; b < 4; b++)
            for (int s = 0; s <= b; s++)
                run_cfg(b, s, 1'((b + s) % 2), (3 * b + s) % 8, (b + 2 * s + 1) % 8, 1'b1);
        // Shortest contention window in standard mode (R7)
        run_cfg(0, 0, 1'b0, 7, 0, 1'b1);
        // No data: own slot never opens (R9)
        run_cfg(0, 0, 1'b1, 0, 3, 1'b0);

        // R11: sparse ticks, then R2 mid-run realignment
        bo = 4'd1; so = 4'd0; tdm_mode = 1'b1; node_slot = 3'd5; data_pending = 1'b1;
        do_start(1'b0);
        for (int k = 0; k < 2400; k++) step(k % 3 == 0);
        chk("R11", "sparse position", pos, 800);
        for (int k = 0; k < 37; k++) step(1'b1);
        do_start(1'b1);
        chk("R2", "restart beacon", int'(beacon_pulse), 1);
        chk("R2", "restart slot", int'(slot_idx), 0);
        for (int k = 0; k < 100; k++) step(1'b1);

        // R10: orders out of range
        so = 4'd2;
        step(1'b1);
        chk("R10", "error flag", int'(cfg_err), 1);
        do_start(1'b1);
        chk("R10", "start ignored", int'(beacon_pulse | active | inactive), 0);
        bo = 4'd15; so = 4'd0;
        step(1'b1);
        chk("R10", "bo too large", int'(cfg_err), 1);
        bo = 4'd1;
        for (int k = 0; k < 20; k++) step(1'b1);
        chk("R10", "idle after fix", int'(active | inactive), 0);
        do_start(1'b0);
        chk("R10", "runs after new start", int'(beacon_pulse), 1);
        for (int k = 0; k < 50; k++) step(1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule